// File: doc/BRIEF.md
# Thermistor Temperature Zone Classifier

This block sorts the battery temperature into charging zones for a charger controller. It takes an 8-bit code for the thermistor divider ratio, where 0 means 0 % and 255 means 100 % of the reference. A higher code means a colder battery. It keeps a registered zone: cold fault, 0–10 °C, 10–45 °C, 45–50 °C, 50–60 °C or hot fault. From the zone it raises a charge-inhibit flag and picks the termination-voltage code and the maximum-current code for that zone.

Each boundary has two trip codes, one for each direction of travel. A boundary moves the zone only when the ratio crosses the code for the direction it is moving in. The two fault edges have wide hysteresis and the inner edges have narrow hysteresis. One input bit selects between two threshold sets, one for a 10 kΩ thermistor and one for a 100 kΩ thermistor. A ratio near full scale means the thermistor is disconnected.

Top module: `therm_zone_sel`

## Requirements
- R1: After reset the block reports `zone` = 7 (unknown), `inhibit` = 1, `open_therm` = 0, and both selected codes are 0.
- R2: Zone encoding: 0 = cold fault, 1 = 0–10 °C, 2 = 10–45 °C, 3 = 45–50 °C, 4 = 50–60 °C, 5 = hot fault, 7 = unknown. The zone and the open flag change only on a clock edge where `sample_valid` is 1, and they are visible right after that edge. While `sample_valid` is 0, all outputs hold.
- R3: Cold fault. A sample above the cold trip code (193 for the 10 kΩ set, 204 for the 100 kΩ set) and not above 242 sets zone 0 from any state. Zone 0 is left only when the ratio falls below the release code (170 or 178).
- R4: Hot fault. A sample below the hot trip code (63 or 49) sets zone 5 from any state. Zone 5 is left only when the ratio rises above the release code (79 or 69).
- R5: Inner boundaries. A move to the warmer zone needs ratio < warm code. A move back to the cooler zone needs ratio > cool code. The 10 kΩ set uses warm/cool codes 167/169 (10 °C), 88/90 (45 °C) and 79/80 (50 °C). The 100 kΩ set uses 175/178, 80/82 and 69/71. A sample may cross several boundaries at once.
- R6: From zone 7, a sample is classified with the cold trip code for the cold edge and the warm codes for every other edge.
- R7: A ratio above 242 (about 95 %) sets `open_therm` = 1 and zone 7. The next valid sample at or below 242 clears the flag and is classified as in R6.
- R8: In zones 1–4, `term_code` = `term_cfg[3*(zone-1) +: 3]`. In every other zone it is 0.
- R9: In zones 1–4, `curr_code` = `curr_cfg[4*(zone-1) +: 4]`. In every other zone it is 0.
- R10: `big_therm` = 0 selects the 10 kΩ codes and 1 selects the 100 kΩ codes. The set in force on a sample's clock edge is the one that applies to it.
- R11: `inhibit` is 1 exactly when the zone is not 1 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_valid | input | 1 | Ratio sample present this cycle |
| ratio | input | 8 | Thermistor/reference ratio code |
| big_therm | input | 1 | Threshold set select (0: 10 kΩ, 1: 100 kΩ) |
| term_cfg | input | 12 | Four 3-bit termination codes, zone 1 in the lowest bits |
| curr_cfg | input | 16 | Four 4-bit current codes, zone 1 in the lowest bits |
| zone | output | 3 | Registered temperature zone |
| inhibit | output | 1 | Charging must stop |
| open_therm | output | 1 | Thermistor absent |
| term_code | output | 3 | Termination code for the active zone |
| curr_code | output | 4 | Current code for the active zone |

## Verification
The assertions assume that `ratio` and `big_therm` are sampled only on edges where `sample_valid` is high. They accept any change of the set bit between samples, and any configuration value. The stimulus mostly moves the ratio by small random steps, so it lingers around each pair of trip codes, and now and then jumps to an arbitrary code, including the open range. Directed samples hit each trip code and the code next to it in both directions. Gaps in `sample_valid` and occasional set flips exercise the hold behaviour and the change of threshold set.

// File: rtl/therm_zone_pkg.sv
// Package: shared zone encoding and threshold tables for the zone classifier.
// Thresholds are kept in per-mille of the reference and scaled to the ratio width.
package therm_zone_pkg;

    typedef enum logic [2:0] {
        ZN_COLD  = 3'd0,
        ZN_0_10  = 3'd1,
        ZN_10_45 = 3'd2,
        ZN_45_50 = 3'd3,
        ZN_50_60 = 3'd4,
        ZN_HOT   = 3'd5,
        ZN_NONE  = 3'd7
    } zone_e;

    localparam int NUM_CHG   = 4;            // charging zones
    localparam int NUM_BOUND = NUM_CHG + 1;  // boundaries, cold edge first

    // Per-mille code a falling ratio (warming battery) must go below to pass boundary k.
    function automatic int warm_pm(input logic big, input int k);
        int r;
        case (k)
            0:       r = big ? 698 : 665;
            1:       r = big ? 686 : 654;
            2:       r = big ? 313 : 345;
            3:       r = big ? 270 : 308;
            default: r = big ? 194 : 249;
        endcase
        return r;
    endfunction

    // Per-mille code a rising ratio (cooling battery) must exceed to undo boundary k.
    function automatic int cool_pm(input logic big, input int k);
        int r;
        case (k)
            0:       r = big ? 800 : 756;
            1:       r = big ? 698 : 662;
            2:       r = big ? 323 : 353;
            3:       r = big ? 278 : 315;
            default: r = big ? 270 : 308;
        endcase
        return r;
    endfunction

    // Rounded conversion from per-mille to a code of the given width.
    function automatic int pm_to_code(input int pm, input int w);
        return (pm * ((1 << w) - 1) + 500) / 1000;
    endfunction

endpackage

// File: rtl/therm_zone_thresh.sv
// Threshold selector: gives the warm and cool trip codes of every boundary
// for the thermistor set picked by big_sel. Assumes thresholds fall with k.
module therm_zone_thresh
    import therm_zone_pkg::*;
#(
    parameter int RATIO_W = 8
) (
    input  logic                               big_sel,
    output logic [NUM_BOUND-1:0][RATIO_W-1:0]  warm_thr,
    output logic [NUM_BOUND-1:0][RATIO_W-1:0]  cool_thr
);

    for (genvar k = 0; k < NUM_BOUND; k++) begin : g_bound
        localparam logic [RATIO_W-1:0] W_SMALL = RATIO_W'(pm_to_code(warm_pm(1'b0, k), RATIO_W));
        localparam logic [RATIO_W-1:0] W_BIG   = RATIO_W'(pm_to_code(warm_pm(1'b1, k), RATIO_W));
        localparam logic [RATIO_W-1:0] C_SMALL = RATIO_W'(pm_to_code(cool_pm(1'b0, k), RATIO_W));
        localparam logic [RATIO_W-1:0] C_BIG   = RATIO_W'(pm_to_code(cool_pm(1'b1, k), RATIO_W));
        // Set mux for this boundary.
        assign warm_thr[k] = big_sel ? W_BIG : W_SMALL;
        assign cool_thr[k] = big_sel ? C_BIG : C_SMALL;
    end

endmodule

// File: rtl/therm_zone_track.sv
// Zone tracker: holds the zone register and applies per-direction thresholds.
// Each boundary counts as passed (warm side) or not; the zone is the number of
// boundaries passed. Assumes thresholds are ordered so passed boundaries form a prefix.
module therm_zone_track
    import therm_zone_pkg::*;
#(
    parameter int RATIO_W = 8,
    parameter int OPEN_PM = 950
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               sample_valid,
    input  logic [RATIO_W-1:0]                 ratio,
    input  logic [NUM_BOUND-1:0][RATIO_W-1:0]  warm_thr,
    input  logic [NUM_BOUND-1:0][RATIO_W-1:0]  cool_thr,
    output zone_e                              zone_q,
    output logic                               open_q
);

    localparam logic [RATIO_W-1:0] OPEN_CODE = RATIO_W'(pm_to_code(OPEN_PM, RATIO_W));

    logic [NUM_BOUND-1:0] passed;
    logic [2:0]           pass_cnt;
    logic                 is_open;

    assign is_open = (ratio > OPEN_CODE);

    for (genvar k = 0; k < NUM_BOUND; k++) begin : g_pass
        // Decide whether boundary k lies behind the battery after this sample.
        always_comb begin
            if (zone_q == ZN_NONE) begin
                passed[k] = (k == 0) ? (ratio <= cool_thr[k]) : (ratio < warm_thr[k]);
            end else if (int'(zone_q) > k) begin
                passed[k] = (ratio <= cool_thr[k]);
            end else begin
                passed[k] = (ratio < warm_thr[k]);
            end
        end
    end

    // Count passed boundaries into the next zone index.
    always_comb begin
        pass_cnt = '0;
        for (int k = 0; k < NUM_BOUND; k++) begin
            pass_cnt = pass_cnt + 3'(passed[k]);
        end
    end

    // Zone and open-thermistor registers, updated on valid samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zone_q <= ZN_NONE;
            open_q <= 1'b0;
        end else if (sample_valid) begin
            if (is_open) begin
                zone_q <= ZN_NONE;
                open_q <= 1'b1;
            end else begin
                zone_q <= zone_e'(pass_cnt);
                open_q <= 1'b0;
            end
        end
    end

    AST_HOLD_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> $stable(zone_q) && $stable(open_q)); // R2

    AST_COLD_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid && (ratio > cool_thr[0]) && (ratio <= OPEN_CODE) |=> zone_q == ZN_COLD); // R3

    AST_HOT_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid && (ratio < warm_thr[NUM_BOUND-1]) |=> zone_q == ZN_HOT); // R4

    AST_OPEN_UNKNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid && (ratio > OPEN_CODE) |=> open_q && (zone_q == ZN_NONE)); // R7

    AST_ZONE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        zone_q != zone_e'(3'd6)); // R2

endmodule

// File: rtl/therm_zone_cfgsel.sv
// Configuration selector: maps the registered zone to its termination and
// current fields and raises inhibit outside the charging zones.
// Assumes field i of each bus belongs to zone i+1.
module therm_zone_cfgsel
    import therm_zone_pkg::*;
#(
    parameter int TERM_W = 3,
    parameter int CURR_W = 4
) (
    input  zone_e                        zone,
    input  logic [NUM_CHG*TERM_W-1:0]    term_cfg,
    input  logic [NUM_CHG*CURR_W-1:0]    curr_cfg,
    output logic [TERM_W-1:0]            term_code,
    output logic [CURR_W-1:0]            curr_code,
    output logic                         inhibit
);

    // Field mux; zero and inhibit when no charging zone is active.
    always_comb begin
        term_code = '0;
        curr_code = '0;
        inhibit   = 1'b1;
        for (int i = 0; i < NUM_CHG; i++) begin
            if (int'(zone) == i + 1) begin
                term_code = term_cfg[i*TERM_W +: TERM_W];
                curr_code = curr_cfg[i*CURR_W +: CURR_W];
                inhibit   = 1'b0;
            end
        end
    end

endmodule

// File: rtl/therm_zone_sel.sv
// Top: battery temperature zone classifier. Picks the threshold set, tracks the
// zone with hysteresis and selects the per-zone charge codes.
// Assumes ratio is a full-scale code of the thermistor-to-reference ratio.
module therm_zone_sel
    import therm_zone_pkg::*;
#(
    parameter int RATIO_W = 8,
    parameter int TERM_W  = 3,
    parameter int CURR_W  = 4,
    parameter int OPEN_PM = 950
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sample_valid,
    input  logic [RATIO_W-1:0]           ratio,
    input  logic                         big_therm,
    input  logic [NUM_CHG*TERM_W-1:0]    term_cfg,
    input  logic [NUM_CHG*CURR_W-1:0]    curr_cfg,
    output logic [2:0]                   zone,
    output logic                         inhibit,
    output logic                         open_therm,
    output logic [TERM_W-1:0]            term_code,
    output logic [CURR_W-1:0]            curr_code
);

    logic [NUM_BOUND-1:0][RATIO_W-1:0] warm_thr;
    logic [NUM_BOUND-1:0][RATIO_W-1:0] cool_thr;
    zone_e                             zone_q;
    logic                              open_q;

    therm_zone_thresh #(.RATIO_W(RATIO_W)) u_thresh (
        .big_sel  (big_therm),
        .warm_thr (warm_thr),
        .cool_thr (cool_thr)
    );

    therm_zone_track #(.RATIO_W(RATIO_W), .OPEN_PM(OPEN_PM)) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (sample_valid),
        .ratio        (ratio),
        .warm_thr     (warm_thr),
        .cool_thr     (cool_thr),
        .zone_q       (zone_q),
        .open_q       (open_q)
    );

    therm_zone_cfgsel #(.TERM_W(TERM_W), .CURR_W(CURR_W)) u_cfgsel (
        .zone      (zone_q),
        .term_cfg  (term_cfg),
        .curr_cfg  (curr_cfg),
        .term_code (term_code),
        .curr_code (curr_code),
        .inhibit   (inhibit)
    );

    assign zone       = zone_q;
    assign open_therm = open_q;

    AST_OPEN_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
        open_therm |-> inhibit); // R7

    AST_FAULT_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((zone == 3'd0) || (zone == 3'd5) || (zone == 3'd7)) |-> inhibit); // R11

    AST_INHIBIT_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |-> (term_code == '0) && (curr_code == '0)); // R8

endmodule

// File: tb/therm_zone_sel_bench.sv
module therm_zone_sel_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_valid = 1'b0;
    logic [7:0]  ratio = '0;
    logic        big_therm = 1'b0;
    logic [11:0] term_cfg = '0;
    logic [15:0] curr_cfg = '0;
    logic [2:0]  zone;
    logic        inhibit;
    logic        open_therm;
    logic [2:0]  term_code;
    logic [3:0]  curr_code;

    int checks = 0;
    int errors = 0;
    int mz = 7;
    bit mopen = 1'b0;

    therm_zone_sel u_therm_zone_sel (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .ratio(ratio),
        .big_therm(big_therm), .term_cfg(term_cfg), .curr_cfg(curr_cfg),
        .zone(zone), .inhibit(inhibit), .open_therm(open_therm),
        .term_code(term_code), .curr_code(curr_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Trip codes from R3, R4, R5 (boundary 0 = cold edge, 4 = hot edge).
    function automatic int warm_code(bit s, int k);
        int t0[5] = '{170, 167, 88, 79, 63};
        int t1[5] = '{178, 175, 80, 69, 49};
        return s ? t1[k] : t0[k];
    endfunction

    function automatic int cool_code(bit s, int k);
        int t0[5] = '{193, 169, 90, 80, 79};
        int t1[5] = '{204, 178, 82, 71, 69};
        return s ? t1[k] : t0[k];
    endfunction

    // Next zone for a non-open sample, per R3 to R6.
    function automatic int next_zone(int z, int r, bit s);
        int n = 0;
        for (int k = 0; k < 5; k++) begin
            bit p;
            if (z == 7)     p = (k == 0) ? (r <= cool_code(s, k)) : (r < warm_code(s, k));
            else if (z > k) p = (r <= cool_code(s, k));
            else            p = (r < warm_code(s, k));
            if (p) n++;
        end
        return n;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        bit chg = (mz >= 1) && (mz <= 4);
        check({tag, " zone"}, int'(zone), mz);
        check({tag, " open R7"}, int'(open_therm), int'(mopen));
        check({tag, " inhibit R11"}, int'(inhibit), chg ? 0 : 1);
        check({tag, " term R8"}, int'(term_code), chg ? int'(term_cfg[3*(mz-1) +: 3]) : 0);
        check({tag, " curr R9"}, int'(curr_cfg[0]) * 0 + int'(curr_code),
              chg ? int'(curr_cfg[4*(mz-1) +: 4]) : 0);
    endtask

    // Called at a falling edge: drive, let one rising edge pass, check.
    task automatic step(int r, bit v, string tag);
        ratio = 8'(r);
        sample_valid = v;
        @(posedge clk);
        if (v) begin
            if (r > 242) begin
                mz = 7; mopen = 1'b1;
            end else begin
                mz = next_zone(mz, r, big_therm); mopen = 1'b0;
            end
        end
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        void'($urandom(32'd1234));
        term_cfg = 12'o7531;
        curr_cfg = 16'hC6A3;
        repeat (3) @(negedge clk);
        check_all("R1 reset");
        rst_n = 1'b1;

        // R2: no sample, no change.
        step(10, 1'b0, "R2 hold");
        // R6: fresh classification.
        step(120, 1'b1, "R6 fresh");
        // R5: 45 C boundary both ways.
        step(88, 1'b1, "R5 at warm code");
        step(87, 1'b1, "R5 below warm");
        step(90, 1'b1, "R5 at cool code");
        step(91, 1'b1, "R5 above cool");
        step(89, 1'b0, "R2 gap");
        // R3: cold trip and release.
        step(194, 1'b1, "R3 trip");
        step(170, 1'b1, "R3 at release");
        step(169, 1'b1, "R3 released");
        step(193, 1'b1, "R3 at trip code");
        // R4: hot trip and release.
        step(62, 1'b1, "R4 trip");
        step(79, 1'b1, "R4 at release");
        step(80, 1'b1, "R4 released");
        // R7: open thermistor.
        step(243, 1'b1, "R7 open");
        step(242, 1'b1, "R7 clear");
        // R10: second set.
        big_therm = 1'b1;
        step(200, 1'b1, "R10 cold hold");
        step(120, 1'b1, "R10 multi-cross");
        step(50, 1'b1, "R10 near hot");
        step(48, 1'b1, "R10 hot trip");
        step(70, 1'b1, "R10 hot release");
        big_therm = 1'b0;
        step(62, 1'b1, "R10 set back");

        // Random walk near the trip codes with occasional jumps.
        begin
            int r = 128;
            for (int i = 0; i < 800; i++) begin
                if ($urandom_range(0, 15) == 0) r = $urandom_range(0, 255);
                else r = r + $urandom_range(0, 12) - 6;
                if (r < 0) r = 0;
                if (r > 255) r = 255;
                if ($urandom_range(0, 49) == 0) big_therm = ~big_therm;
                if ($urandom_range(0, 99) == 0) begin
                    term_cfg = 12'($urandom);
                    curr_cfg = 16'($urandom);
                end
                step(r, $urandom_range(0, 99) < 85, "R5 random");
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule